// File: doc/BRIEF.md
# Floating-point sign-injection unit with NaN-box checking

This unit computes the three sign-injection results for single- or double-precision values held in 64-bit floating-point registers. Every non-sign bit of the result comes from operand A. The sign comes from operand B in one of three ways: copied, inverted, or XORed with A's own sign. Single-precision operands must arrive NaN-boxed. An operand that is not boxed is replaced by the default quiet NaN before use, and every single-precision result leaves the unit boxed.

The core that uses this unit can also route arithmetic results through it with the canonicalize enable set. In that mode, any NaN among the operands or the raw result turns the output into the default quiet NaN of the selected precision. An invalid-operation flag is raised when one of those values is a signalling NaN. With the enable clear, the unit performs plain sign injection and never raises the flag.

The outputs are registered, so a result appears one clock after its inputs.

Top module: `fsgn_unit`

## Requirements
- R1: A synchronous active-high reset clears `result` and `invalid` to zero. After reset, each output reflects the inputs that were present at the preceding rising clock edge, so latency is exactly one cycle.
- R2: `sgn_mode` selects the sign source. 2'b00 copies B's sign. 2'b01 uses the inverted sign of B. 2'b10 uses A's sign XOR B's sign. 2'b11 behaves like 2'b00. All other bits of the result are A's bits.
- R3: When `is_dbl` is 1, the sign is bit 63 of each operand, and bits 62:0 of the result equal bits 62:0 of A.
- R4: When `is_dbl` is 0, the sign is bit 31 of each operand, and bits 30:0 of the result equal bits 30:0 of A. Bits 63:32 of every single-precision result are all ones.
- R5: In single precision, an operand whose bits 63:32 are not all ones is taken as 0x7FC00000 before sign injection and NaN checks.
- R6: When `canon_en` is 0, no NaN replacement takes place and `invalid` stays 0, even for signalling NaN operands.
- R7: When `canon_en` is 1 and A, B or the raw result is a NaN, the result is 0x7FF8000000000000 in double precision or 0xFFFFFFFF7FC00000 in single precision. Infinities are not NaNs and pass through unchanged.
- R8: When `canon_en` is 1, `invalid` is 1 exactly when A, B or the raw result is a signalling NaN. A signalling NaN has an all-ones exponent, a nonzero fraction, and a clear quiet bit (bit 51 for double, bit 22 for single).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 64 | Operand supplying magnitude and, in XOR mode, a sign |
| op_b | input | 64 | Operand supplying the sign |
| is_dbl | input | 1 | 1 selects double precision, 0 selects single precision |
| sgn_mode | input | 2 | Sign-source select (copy, invert, XOR) |
| canon_en | input | 1 | Enables NaN canonicalization and the invalid flag |
| result | output | 64 | Registered result, boxed when single precision |
| invalid | output | 1 | Registered invalid-operation flag |

## Verification
Within one cycle, box validation, sign injection and NaN canonicalization can all act on the same operation. The main interaction is an unboxed single operand: it becomes a quiet NaN, and canonicalization then has to override the injected sign while leaving the flag low. A signalling NaN in B alone is another such case: B contributes only its sign, yet it must still trigger both replacement and the flag. Directed vectors provoke these collisions, and random operands mixed from boxed, unboxed, quiet-NaN, signalling-NaN and infinity patterns are judged against a bench model written from the requirements.

// File: rtl/fsgn_pkg.sv
package fsgn_pkg;

  typedef enum logic [1:0] {
    SGN_COPY = 2'b00,
    SGN_NEG  = 2'b01,
    SGN_XOR  = 2'b10,
    SGN_ALT  = 2'b11
  } sgn_mode_e;

  typedef struct packed {
    logic is_nan;
    logic is_snan;
  } nan_cls_t;

endpackage

// File: rtl/fsgn_unbox.sv
module fsgn_unbox #(
  parameter int EXP_D = 11,
  parameter int MAN_D = 52,
  parameter int EXP_S = 8,
  parameter int MAN_S = 23
) (
  input  logic                     is_dbl,
  input  logic [EXP_D+MAN_D:0]     raw,
  output logic [EXP_D+MAN_D:0]     opnd
);
  localparam int FLEN = 1 + EXP_D + MAN_D;
  localparam int SLEN = 1 + EXP_S + MAN_S;
  localparam int HLEN = FLEN - SLEN;
  localparam logic [SLEN-1:0] QNAN_S = {1'b0, {EXP_S{1'b1}}, 1'b1, {(MAN_S-1){1'b0}}};

  logic boxed;

  // A single value is only legal when the upper part is all ones.
  assign boxed = &raw[FLEN-1:SLEN];

  always_comb begin
    if (is_dbl)     opnd = raw;
    else if (boxed) opnd = raw;
    else            opnd = {{HLEN{1'b1}}, QNAN_S};
  end
endmodule

// File: rtl/fsgn_classify.sv
module fsgn_classify
  import fsgn_pkg::*;
#(
  parameter int EXP_D = 11,
  parameter int MAN_D = 52,
  parameter int EXP_S = 8,
  parameter int MAN_S = 23
) (
  input  logic                   is_dbl,
  input  logic [EXP_D+MAN_D-1:0] mag,
  output nan_cls_t               cls
);
  localparam int SLEN = 1 + EXP_S + MAN_S;

  logic exp_ones_d, frac_nz_d, exp_ones_s, frac_nz_s;

  assign exp_ones_d = &mag[EXP_D+MAN_D-1:MAN_D];
  assign frac_nz_d  = |mag[MAN_D-1:0];
  assign exp_ones_s = &mag[SLEN-2:MAN_S];
  assign frac_nz_s  = |mag[MAN_S-1:0];

  always_comb begin
    if (is_dbl) begin
      cls.is_nan  = exp_ones_d & frac_nz_d;
      cls.is_snan = exp_ones_d & frac_nz_d & ~mag[MAN_D-1];
    end else begin
      cls.is_nan  = exp_ones_s & frac_nz_s;
      cls.is_snan = exp_ones_s & frac_nz_s & ~mag[MAN_S-1];
    end
  end
endmodule

// File: rtl/fsgn_inject.sv
module fsgn_inject
  import fsgn_pkg::*;
#(
  parameter int EXP_D = 11,
  parameter int MAN_D = 52,
  parameter int EXP_S = 8,
  parameter int MAN_S = 23
) (
  input  logic                 is_dbl,
  input  logic [1:0]           sgn_mode,
  input  logic [EXP_D+MAN_D:0] a,
  input  logic                 b_sign_d,
  input  logic                 b_sign_s,
  output logic [EXP_D+MAN_D:0] raw
);
  localparam int FLEN = 1 + EXP_D + MAN_D;
  localparam int SLEN = 1 + EXP_S + MAN_S;
  localparam int HLEN = FLEN - SLEN;

  logic      sa, sb, s_new;
  sgn_mode_e mode;

  assign mode = sgn_mode_e'(sgn_mode);
  assign sa   = is_dbl ? a[FLEN-1] : a[SLEN-1];
  assign sb   = is_dbl ? b_sign_d  : b_sign_s;

  always_comb begin
    unique case (mode)
      SGN_NEG: s_new = ~sb;
      SGN_XOR: s_new = sa ^ sb;
      default: s_new = sb;
    endcase
  end

  always_comb begin
    if (is_dbl) raw = {s_new, a[FLEN-2:0]};
    else        raw = {{HLEN{1'b1}}, s_new, a[SLEN-2:0]};
  end
endmodule

// File: rtl/fsgn_unit.sv
module fsgn_unit
  import fsgn_pkg::*;
#(
  parameter int EXP_D = 11,
  parameter int MAN_D = 52,
  parameter int EXP_S = 8,
  parameter int MAN_S = 23
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [EXP_D+MAN_D:0] op_a,
  input  logic [EXP_D+MAN_D:0] op_b,
  input  logic                 is_dbl,
  input  logic [1:0]           sgn_mode,
  input  logic                 canon_en,
  output logic [EXP_D+MAN_D:0] result,
  output logic                 invalid
);
  localparam int FLEN  = 1 + EXP_D + MAN_D;
  localparam int SLEN  = 1 + EXP_S + MAN_S;
  localparam int HLEN  = FLEN - SLEN;
  localparam int NOPND = 2;
  localparam int NCLS  = NOPND + 1;
  localparam logic [FLEN-1:0] QNAN_D = {1'b0, {EXP_D{1'b1}}, 1'b1, {(MAN_D-1){1'b0}}};
  localparam logic [FLEN-1:0] QNAN_S = {{HLEN{1'b1}}, 1'b0, {EXP_S{1'b1}}, 1'b1, {(MAN_S-1){1'b0}}};

  logic [FLEN-1:0] opnd_in [NOPND];
  logic [FLEN-1:0] opnd    [NOPND];
  logic [FLEN-1:0] raw;
  logic [FLEN-1:0] cls_val [NCLS];
  nan_cls_t        cls     [NCLS];
  logic [NCLS-1:0] nan_vec, snan_vec;
  logic [FLEN-1:0] res_next;
  logic            inv_next;

  assign opnd_in[0] = op_a;
  assign opnd_in[1] = op_b;

  // Box check on each source operand.
  for (genvar g = 0; g < NOPND; g++) begin : g_unbox
    fsgn_unbox #(.EXP_D(EXP_D), .MAN_D(MAN_D), .EXP_S(EXP_S), .MAN_S(MAN_S)) u_unbox (
      .is_dbl (is_dbl),
      .raw    (opnd_in[g]),
      .opnd   (opnd[g])
    );
  end

  fsgn_inject #(.EXP_D(EXP_D), .MAN_D(MAN_D), .EXP_S(EXP_S), .MAN_S(MAN_S)) u_inject (
    .is_dbl   (is_dbl),
    .sgn_mode (sgn_mode),
    .a        (opnd[0]),
    .b_sign_d (opnd[1][FLEN-1]),
    .b_sign_s (opnd[1][SLEN-1]),
    .raw      (raw)
  );

  assign cls_val[0] = opnd[0];
  assign cls_val[1] = opnd[1];
  assign cls_val[2] = raw;

  // NaN classification of both operands and the raw result.
  for (genvar g = 0; g < NCLS; g++) begin : g_cls
    fsgn_classify #(.EXP_D(EXP_D), .MAN_D(MAN_D), .EXP_S(EXP_S), .MAN_S(MAN_S)) u_cls (
      .is_dbl (is_dbl),
      .mag    (cls_val[g][FLEN-2:0]),
      .cls    (cls[g])
    );
    assign nan_vec[g]  = cls[g].is_nan;
    assign snan_vec[g] = cls[g].is_snan;
  end

  always_comb begin
    res_next = raw;
    if (canon_en && (|nan_vec)) res_next = is_dbl ? QNAN_D : QNAN_S;
    inv_next = canon_en & (|snan_vec);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result  <= '0;
      invalid <= 1'b0;
    end else begin
      result  <= res_next;
      invalid <= inv_next;
    end
  end

  // R1: reset clears the registered outputs
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (result == '0 && !invalid));

  // R4: single results always leave boxed
  a_r4_boxed_out: assert property (@(posedge clk) disable iff (rst)
    !is_dbl |=> (&result[FLEN-1:SLEN]));

  // R3: double magnitude passes from A when canonicalization is off
  a_r3_dbl_mag: assert property (@(posedge clk) disable iff (rst)
    (is_dbl && !canon_en) |=> (result[FLEN-2:0] == $past(op_a[FLEN-2:0])));

  // R6: no flag without the canonicalize enable
  a_r6_no_flag: assert property (@(posedge clk) disable iff (rst)
    !canon_en |=> !invalid);

  // R7: a NaN in B alone forces the default double NaN
  a_r7_b_nan_canon: assert property (@(posedge clk) disable iff (rst)
    (canon_en && is_dbl && (&op_b[FLEN-2:MAN_D]) && (|op_b[MAN_D-1:0]))
      |=> (result == QNAN_D));

  // R8: a signalling double NaN in A raises the flag
  a_r8_snan_flag: assert property (@(posedge clk) disable iff (rst)
    (canon_en && is_dbl && (&op_a[FLEN-2:MAN_D]) && (|op_a[MAN_D-1:0]) && !op_a[MAN_D-1])
      |=> invalid);

endmodule

// File: tb/fsgn_unit_tb_top.sv
`timescale 1ns/1ps
module fsgn_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] op_a = '0, op_b = '0;
  logic        is_dbl = 1'b0, canon_en = 1'b0;
  logic [1:0]  sgn_mode = 2'b00;
  logic [63:0] result;
  logic        invalid;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  fsgn_unit dut_i (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .is_dbl(is_dbl),
    .sgn_mode(sgn_mode), .canon_en(canon_en), .result(result), .invalid(invalid)
  );

  function automatic bit d_nan(logic [63:0] x);
    return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
  endfunction
  function automatic bit s_nan(logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction

  // Expected {invalid, result} from the requirements.
  function automatic logic [64:0] model(logic [63:0] a, logic [63:0] b, bit dbl,
                                        logic [1:0] m, bit ce);
    logic [63:0] r;
    bit sa, sb, s, na, nb, nr, xa, xb, xr;
    logic [31:0] ua, ub, rs;
    if (dbl) begin
      sa = a[63]; sb = b[63];
      s  = (m == 2'b01) ? ~sb : (m == 2'b10) ? (sa ^ sb) : sb;
      r  = {s, a[62:0]};
      na = d_nan(a); nb = d_nan(b); nr = d_nan(r);
      xa = na && !a[51]; xb = nb && !b[51]; xr = nr && !r[51];
      if (ce && (na || nb || nr)) r = 64'h7FF8000000000000;
    end else begin
      ua = (a[63:32] == 32'hFFFFFFFF) ? a[31:0] : 32'h7FC00000;
      ub = (b[63:32] == 32'hFFFFFFFF) ? b[31:0] : 32'h7FC00000;
      sa = ua[31]; sb = ub[31];
      s  = (m == 2'b01) ? ~sb : (m == 2'b10) ? (sa ^ sb) : sb;
      rs = {s, ua[30:0]};
      na = s_nan(ua); nb = s_nan(ub); nr = s_nan(rs);
      xa = na && !ua[22]; xb = nb && !ub[22]; xr = nr && !rs[22];
      r  = {32'hFFFFFFFF, rs};
      if (ce && (na || nb || nr)) r = 64'hFFFFFFFF7FC00000;
    end
    return {ce && (xa || xb || xr), r};
  endfunction

  task automatic check(string req, logic [63:0] er, logic ei);
    n_checks++;
    if (result !== er || invalid !== ei) begin
      n_fail++;
      $display("FAIL %s: result=%h invalid=%b expected result=%h invalid=%b",
               req, result, invalid, er, ei);
    end
  endtask

  // Drive at a falling edge, sample one cycle later at the next falling edge.
  task automatic run(string req, logic [63:0] a, logic [63:0] b, bit dbl,
                     logic [1:0] m, bit ce, logic [63:0] er, logic ei);
    @(negedge clk);
    op_a = a; op_b = b; is_dbl = dbl; sgn_mode = m; canon_en = ce;
    @(negedge clk);
    check(req, er, ei);
  endtask

  function automatic logic [63:0] pick();
    logic [63:0] x = {$urandom, $urandom};
    case ($urandom % 7)
      0: return x;
      1: return {32'hFFFFFFFF, x[31:0]};
      2: return {32'hFFFFFFFF, x[31], 8'hFF, x[22:0] | 23'h1};
      3: return {x[63], 11'h7FF, x[51:0] | 52'h1};
      4: return {x[63], 11'h7FF, 52'h0};
      5: return {32'hFFFFFFFF, x[31], 8'hFF, 23'h0};
      default: return {x[63:33], 1'b0, x[31:0]};
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: result=%h invalid=%b expected completion", result, invalid);
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R1: reset holds outputs at zero despite active inputs
    op_a = 64'h7FF0000000000001; op_b = 64'h8000000000000000;
    is_dbl = 1; canon_en = 1;
    repeat (3) @(negedge clk);
    check("R1 reset", 64'h0, 1'b0);
    rst = 0;
    // R1: one-cycle latency after reset release
    run("R1 latency", 64'h3FF0000000000000, 64'h8000000000000000, 1, 2'b00, 0,
        64'hBFF0000000000000, 0);
    // R2/R3 modes in double
    run("R2 neg mode", 64'hC000000000000000, 64'h0, 1, 2'b01, 0, 64'hC000000000000000, 0);
    run("R2 xor mode", 64'hBFF0000000000000, 64'h8000000000000000, 1, 2'b10, 0,
        64'h3FF0000000000000, 0);
    run("R2 alt mode", 64'h3FF0000000000000, 64'hC000000000000000, 1, 2'b11, 0,
        64'hBFF0000000000000, 0);
    run("R3 dbl mag", 64'h8123456789ABCDEF, 64'h7FFFFFFFFFFFFFFF, 1, 2'b00, 0,
        64'h0123456789ABCDEF, 0);
    // R4 single boxed
    run("R4 single copy", 64'hFFFFFFFF3F800000, 64'hFFFFFFFFBF800000, 0, 2'b00, 0,
        64'hFFFFFFFFBF800000, 0);
    run("R4 single xor", 64'hFFFFFFFFC0490FDB, 64'hFFFFFFFF80000000, 0, 2'b10, 0,
        64'hFFFFFFFF40490FDB, 0);
    // R5 unboxed operands
    run("R5 unboxed A", 64'h000000003F800000, 64'hFFFFFFFFBF800000, 0, 2'b00, 0,
        64'hFFFFFFFFFFC00000, 0);
    run("R5 unboxed B", 64'hFFFFFFFFBF800000, 64'h7FFFFFFF00000000, 0, 2'b00, 0,
        64'hFFFFFFFF3F800000, 0);
    run("R5 R7 unboxed B canon", 64'hFFFFFFFFBF800000, 64'h0, 0, 2'b00, 1,
        64'hFFFFFFFF7FC00000, 0);
    // R6 no canonicalization
    run("R6 snan passthrough", 64'h7FF0000000000001, 64'h8000000000000000, 1, 2'b00, 0,
        64'hFFF0000000000001, 0);
    // R7/R8 canonicalization and flag
    run("R8 snan A dbl", 64'h7FF0000000000001, 64'h8000000000000000, 1, 2'b00, 1,
        64'h7FF8000000000000, 1);
    run("R8 snan B dbl", 64'h3FF0000000000000, 64'hFFF4000000000000, 1, 2'b01, 1,
        64'h7FF8000000000000, 1);
    run("R7 qnan B dbl", 64'h3FF0000000000000, 64'hFFF8000000000001, 1, 2'b00, 1,
        64'h7FF8000000000000, 0);
    run("R8 snan A single", 64'hFFFFFFFF7F800001, 64'hFFFFFFFF00000000, 0, 2'b00, 1,
        64'hFFFFFFFF7FC00000, 1);
    run("R7 inf not nan", 64'h7FF0000000000000, 64'h8000000000000000, 1, 2'b00, 1,
        64'hFFF0000000000000, 0);
    run("R7 arith pass", 64'h4000000000000000, 64'h8000000000000000, 1, 2'b10, 1,
        64'hC000000000000000, 0);
    // Random mix, R2 R3 R4 R5 R7 R8
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] a = pick();
      logic [63:0] b = pick();
      bit dbl = $urandom % 2;
      logic [1:0] m = 2'($urandom);
      bit ce = $urandom % 2;
      logic [64:0] e = model(a, b, dbl, m, ce);
      run("R2 R7 R8 random", a, b, dbl, m, ce, e[63:0], e[64]);
    end
    // R1: reset in mid-stream clears again
    @(negedge clk); rst = 1;
    @(negedge clk); check("R1 re-reset", 64'h0, 1'b0);
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule